// File: doc/BRIEF.md
# PCI Controller Start-Up Gate

This block sits between a CPU register port and the bus-facing side of a PCI controller. It decides, during and after start-up, which CPU register accesses take effect and whether outbound master requests may reach the bus. It also decides whether accesses from external bus masters are accepted or answered with a retry, and whether the host arbiter rotates grants among external requesters or keeps the grant parked on the controller. Its decisions rest on a two-step bring-up. Software first sets an enable bit. It then loads eight configuration registers and finally sets an init-complete bit, which stays set until reset.

A strap input picks host mode or device mode and is captured only while reset is high. In host mode the block also arbitrates among four external request lines and the controller itself. In device mode an external arbiter owns the bus, so this block drives no grants.

The CPU register port and the outbound request port are valid/ready interfaces. The register port is always ready, and every accepted request gets exactly one response on the next cycle, with no back-pressure on responses. The outbound port holds `ob_valid` until `ob_ready`. While the path is open, `bus_req_ready` back-pressures it. While the path is blocked, the request is taken at once. Each taken request produces a one-cycle `ob_done` with `ob_err` on the next cycle.

Top module: `pci_init_gate`

## Requirements
- R1: After reset the enable and init-complete bits are 0, `cpu_rsp_valid` and `ob_done` are 0, and in host mode `self_gnt` is 1 with `ext_gnt` all zero.
- R2: The enable register (address 0, bit 0) can be written and read at any time. Every accepted register request returns `cpu_rsp_valid`=1 on the next cycle.
- R3: While enable is 0, writes to addresses 1 to 15 are dropped and reads of them return 0.
- R4: While enable is 1 and init-complete is 0, the eight configuration registers are written and read back in full. They sit at addresses 2 to 9 (command, status, subsystem vendor ID, subsystem ID, local size 0 and 1, local address 0 and 1). Addresses 10 to 15 read as 0.
- R5: When enable is 1, writing 1 to bit 0 of address 1 sets init-complete. Once set, it stays set until reset, and writing 0 does not clear it.
- R6: Once init-complete is 1, writes to the eight configuration registers are ignored.
- R7: While enable or init-complete is 0, an outbound request is blocked. `ob_ready` is 1 and `bus_req_valid` stays 0. On the next cycle `ob_done`=1 and `ob_err`=1.
- R8: While the path is open, `bus_req_valid` follows `ob_valid`. In host mode it also needs `self_gnt`. `ob_ready` equals `bus_req_ready`, and the cycle after the handshake gives `ob_done`=1 with `ob_err`=0.
- R9: While init-complete is 0, every `tgt_valid` cycle gets `tgt_retry`=1 and `tgt_accept`=0. Once it is 1, every `tgt_valid` cycle gets `tgt_accept`=1 and `tgt_retry`=0.
- R10: In host mode with init-complete at 0, `ext_gnt` stays 0 and `self_gnt` stays 1 whatever `ext_req` does.
- R11: In host mode with init-complete at 1, at most one grant is active. Grant changes take one cycle. The owner keeps the grant while it requests. Otherwise the grant moves to the next requester in rotation order controller, ext 0, 1, 2, 3, counted from the current owner. With no requester the grant parks on the controller.
- R12: In device mode `ext_gnt` and `self_gnt` stay 0, and outbound requests need no grant.
- R13: The mode strap is sampled only while reset is high, and later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; strap is captured while high |
| strap_host | input | 1 | 1 = host mode, 0 = device mode |
| cpu_req_valid | input | 1 | Register request valid |
| cpu_req_ready | output | 1 | Register request ready (always 1) |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 4 | Register address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Response valid, one cycle after the request |
| cpu_rsp_rdata | output | DATA_W | Read data (0 for writes and gated reads) |
| ob_valid | input | 1 | Outbound CPU request valid |
| ob_ready | output | 1 | Outbound request taken |
| ob_done | output | 1 | Outbound completion pulse |
| ob_err | output | 1 | Completion was a blocked request |
| bus_req_valid | output | 1 | Master cycle request toward the bus engine |
| bus_req_ready | input | 1 | Bus engine takes the master request |
| tgt_valid | input | 1 | External master access present |
| tgt_accept | output | 1 | Access accepted |
| tgt_retry | output | 1 | Access answered with retry |
| ext_req | input | N_EXT | External bus requests (host mode) |
| ext_gnt | output | N_EXT | External bus grants (host mode) |
| self_gnt | output | 1 | Bus granted to the controller itself |

## Verification
A wrong enable or init-complete bit shows within one cycle. `tgt_retry`/`tgt_accept` and `bus_req_valid` are combinational from these bits, and a blocked request reports `ob_err` on the very next cycle. A wrong stored grant shows one cycle after a request change, as a grant to the wrong line or to more than one line. A lost write or a write that should have been dropped shows on the next read of that address. The bench sweeps every request mask and every register address, so such faults surface at the first affected access.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NCFG     = 8;
  localparam int unsigned CFG_BASE = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE = 4'd0,
    A_CTRL   = 4'd1,
    A_CMD    = 4'd2,
    A_STAT   = 4'd3,
    A_SVID   = 4'd4,
    A_SID    = 4'd5,
    A_LSZ0   = 4'd6,
    A_LSZ1   = 4'd7,
    A_LAD0   = 4'd8,
    A_LAD1   = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/pig_regs.sv
module pig_regs
  import pig_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              en_o,
  output logic              init_o
);
  logic              en_q, init_q;
  logic [DATA_W-1:0] cfg_q [NCFG];
  logic [DATA_W-1:0] rd_val;
  logic              wr_any, cfg_open;

  assign wr_any   = req_valid && req_we;
  assign cfg_open = en_q && !init_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      init_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_we) ? rd_val : '0;
      if (wr_any && req_addr == ADDR_W'(A_ENABLE))
        en_q <= req_wdata[0];
      // init-complete is sticky: only a set is honoured
      if (wr_any && en_q && req_addr == ADDR_W'(A_CTRL) && req_wdata[0])
        init_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_BASE + g);
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= '0;
      else if (wr_any && cfg_open && req_addr == MY_ADDR)
        cfg_q[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (req_addr == ADDR_W'(A_ENABLE)) begin
      rd_val[0] = en_q;
    end else if (en_q) begin
      if (req_addr == ADDR_W'(A_CTRL)) rd_val[0] = init_q;
      for (int g = 0; g < NCFG; g++)
        if (req_addr == ADDR_W'(CFG_BASE + g)) rd_val = cfg_q[g];
    end
  end

  assign en_o   = en_q;
  assign init_o = init_q;
endmodule

// File: rtl/pig_arb.sv
module pig_arb #(
  parameter int unsigned N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host,
  input  logic             init,
  input  logic             self_req,
  input  logic [N_EXT-1:0] ext_req,
  output logic [N_EXT-1:0] ext_gnt,
  output logic             self_gnt
);
  localparam int N  = N_EXT + 1;
  localparam int IW = $clog2(N);

  logic [N-1:0]  req_all, gnt_q, gnt_d, pick;
  logic [IW-1:0] owner;
  logic          found;

  assign req_all = {ext_req, self_req};

  always_comb begin
    owner = '0;
    for (int i = 0; i < N; i++)
      if (gnt_q[i]) owner = IW'(i);
  end

  // rotate from the slot after the current owner
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(owner) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_all[idx]) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    if (!host)                    gnt_d = '0;
    else if (!init)               gnt_d = N'(1);
    else if (|(gnt_q & req_all))  gnt_d = gnt_q;
    else if (found)               gnt_d = pick;
    else                          gnt_d = N'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= '0;
    else     gnt_q <= gnt_d;
  end

  assign self_gnt = host && (!init || gnt_q[0]);
  assign ext_gnt  = (host && init) ? gnt_q[N-1:1] : '0;
endmodule

// File: rtl/pig_gate.sv
module pig_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic init,
  input  logic host,
  input  logic self_gnt,
  input  logic ob_valid,
  output logic ob_ready,
  output logic ob_done,
  output logic ob_err,
  output logic bus_req_valid,
  input  logic bus_req_ready,
  output logic self_req,
  input  logic tgt_valid,
  output logic tgt_accept,
  output logic tgt_retry
);
  logic open_path, path_ok, take;

  assign open_path     = en && init;
  assign path_ok       = open_path && (!host || self_gnt);
  assign bus_req_valid = ob_valid && path_ok;
  assign ob_ready      = open_path ? (path_ok && bus_req_ready) : 1'b1;
  assign self_req      = ob_valid && open_path;
  assign take          = ob_valid && ob_ready;

  assign tgt_retry  = tgt_valid && !init;
  assign tgt_accept = tgt_valid && init;

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_done <= 1'b0;
      ob_err  <= 1'b0;
    end else begin
      ob_done <= take;
      ob_err  <= take && !open_path;
    end
  end
endmodule

// File: rtl/pci_init_gate.sv
module pci_init_gate
  import pig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_EXT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_host,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              ob_valid,
  output logic              ob_ready,
  output logic              ob_done,
  output logic              ob_err,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  input  logic              tgt_valid,
  output logic              tgt_accept,
  output logic              tgt_retry,
  input  logic [N_EXT-1:0]  ext_req,
  output logic [N_EXT-1:0]  ext_gnt,
  output logic              self_gnt
);
  logic host_q, en_q, init_q, self_req;

  always_ff @(posedge clk) begin
    if (rst) host_q <= strap_host;
  end

  assign cpu_req_ready = 1'b1;

  pig_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_valid (cpu_req_valid),
    .req_we    (cpu_req_we),
    .req_addr  (cpu_req_addr),
    .req_wdata (cpu_req_wdata),
    .rsp_valid (cpu_rsp_valid),
    .rsp_rdata (cpu_rsp_rdata),
    .en_o      (en_q),
    .init_o    (init_q)
  );

  pig_arb #(.N_EXT(N_EXT)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .host     (host_q),
    .init     (init_q),
    .self_req (self_req),
    .ext_req  (ext_req),
    .ext_gnt  (ext_gnt),
    .self_gnt (self_gnt)
  );

  pig_gate u_gate (
    .clk           (clk),
    .rst           (rst),
    .en            (en_q),
    .init          (init_q),
    .host          (host_q),
    .self_gnt      (self_gnt),
    .ob_valid      (ob_valid),
    .ob_ready      (ob_ready),
    .ob_done       (ob_done),
    .ob_err        (ob_err),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .self_req      (self_req),
    .tgt_valid     (tgt_valid),
    .tgt_accept    (tgt_accept),
    .tgt_retry     (tgt_retry)
  );
endmodule

// File: rtl/pci_init_gate_chk.sv
module pci_init_gate_chk #(
  parameter int unsigned N_EXT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             host_q,
  input logic             en_q,
  input logic             init_q,
  input logic             ob_valid,
  input logic             ob_done,
  input logic             ob_err,
  input logic             bus_req_valid,
  input logic             tgt_valid,
  input logic             tgt_accept,
  input logic             tgt_retry,
  input logic [N_EXT-1:0] ext_gnt,
  input logic             self_gnt
);
  // R10
  host_park_chk: assert property (@(posedge clk) disable iff (rst)
    (host_q && !init_q) |-> (self_gnt && ext_gnt == '0));

  // R11
  one_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_gnt, self_gnt}));

  // R7
  blocked_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !(en_q && init_q) |-> !bus_req_valid);

  // R7
  blocked_err_chk: assert property (@(posedge clk) disable iff (rst)
    (ob_valid && !(en_q && init_q)) |=> (ob_done && ob_err));

  // R8
  bus_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> ob_valid);

  // R9
  retry_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && !init_q) |-> (tgt_retry && !tgt_accept));

  // R5
  init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_q |=> init_q);

  // R12
  device_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
    !host_q |-> (ext_gnt == '0 && !self_gnt));

  // R13
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(host_q));
endmodule

bind pci_init_gate pci_init_gate_chk #(.N_EXT(N_EXT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .host_q        (host_q),
  .en_q          (en_q),
  .init_q        (init_q),
  .ob_valid      (ob_valid),
  .ob_done       (ob_done),
  .ob_err        (ob_err),
  .bus_req_valid (bus_req_valid),
  .tgt_valid     (tgt_valid),
  .tgt_accept    (tgt_accept),
  .tgt_retry     (tgt_retry),
  .ext_gnt       (ext_gnt),
  .self_gnt      (self_gnt)
);

// File: tb/pci_init_gate_bench.sv
module pci_init_gate_bench;
  localparam int DW = 32;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap_host = 1'b1;
  logic          cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_we = 1'b0;
  logic [3:0]    cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          ob_valid = 1'b0, ob_ready, ob_done, ob_err;
  logic          bus_req_valid, bus_req_ready = 1'b0;
  logic          tgt_valid = 1'b0, tgt_accept, tgt_retry;
  logic [NE-1:0] ext_req = '0, ext_gnt;
  logic          self_gnt;

  int tests = 0, fails = 0;
  logic [DW-1:0] rd;

  always #5 clk = ~clk;

  pci_init_gate #(.DATA_W(DW), .N_EXT(NE)) u_pci_init_gate (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu(input logic we, input logic [3:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] r);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0; cpu_req_we = 1'b0;
    r = cpu_rsp_rdata;
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return DW'(32'h5A00_0000 + salt * 32'h0011_0000 + i * 32'h0101);
  endfunction

  task automatic do_reset(input logic host);
    @(negedge clk);
    rst = 1'b1; strap_host = host;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic blocked_ob(input string tag);
    @(negedge clk);
    ob_valid = 1'b1;
    #1;
    chk({tag, " ready"}, DW'(ob_ready), 1);
    chk({tag, " busreq"}, DW'(bus_req_valid), 0);
    @(negedge clk);
    ob_valid = 1'b0;
    chk({tag, " done/err"}, DW'({ob_done, ob_err}), 3);
  endtask

  initial begin
    // ---------------- host mode ----------------
    do_reset(1'b1);
    @(negedge clk);
    // R1
    chk("R1 rsp_valid", DW'(cpu_rsp_valid), 0);
    chk("R1 ob_done", DW'(ob_done), 0);
    chk("R1 self_gnt", DW'(self_gnt), 1);
    chk("R1 ext_gnt", DW'(ext_gnt), 0);
    cpu(1'b0, 4'd0, '0, rd);
    chk("R1 enable reads 0", rd, 0);

    // R3: disabled, writes dropped, init write dropped
    for (int i = 0; i < 8; i++) cpu(1'b1, 4'(2 + i), pat(i, 1), rd);
    cpu(1'b1, 4'd1, 1, rd);
    for (int a = 1; a < 16; a++) begin
      cpu(1'b0, 4'(a), '0, rd);
      chk("R3 gated read", rd, 0);
    end
    // R7 disabled
    blocked_ob("R7 disabled");

    // R2: enable
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = 4'd0; cpu_req_wdata = 1;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk("R2 rsp_valid", DW'(cpu_rsp_valid), 1);
    chk("R2 ready", DW'(cpu_req_ready), 1);
    cpu(1'b0, 4'd0, '0, rd);
    chk("R2 enable readback", rd, 1);
    // R3 effect: earlier writes were dropped, init still clear
    for (int i = 0; i < 8; i++) begin
      cpu(1'b0, 4'(2 + i), '0, rd);
      chk("R3 dropped write", rd, 0);
    end
    cpu(1'b0, 4'd1, '0, rd);
    chk("R3 init untouched", rd, 0);

    // R10 / R9 before init
    ext_req = 4'hF; tgt_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ext_gnt", DW'(ext_gnt), 0);
    chk("R10 self_gnt", DW'(self_gnt), 1);
    chk("R9 retry pre-init", DW'({tgt_retry, tgt_accept}), 2);
    ext_req = '0; tgt_valid = 1'b0;

    // R4 config sweep
    for (int i = 0; i < 8; i++) cpu(1'b1, 4'(2 + i), pat(i, 2), rd);
    for (int i = 0; i < 8; i++) begin
      cpu(1'b0, 4'(2 + i), '0, rd);
      chk("R4 cfg readback", rd, pat(i, 2));
    end
    for (int a = 10; a < 16; a++) begin
      cpu(1'b0, 4'(a), '0, rd);
      chk("R4 unmapped", rd, 0);
    end
    // R7 enabled but not init
    blocked_ob("R7 pre-init");

    // R5 set init, try to clear
    cpu(1'b1, 4'd1, 1, rd);
    cpu(1'b0, 4'd1, '0, rd);
    chk("R5 init set", rd, 1);
    cpu(1'b1, 4'd1, 0, rd);
    cpu(1'b0, 4'd1, '0, rd);
    chk("R5 init sticky", rd, 1);

    // R6 locked
    for (int i = 0; i < 8; i++) cpu(1'b1, 4'(2 + i), pat(i, 3), rd);
    for (int i = 0; i < 8; i++) begin
      cpu(1'b0, 4'(2 + i), '0, rd);
      chk("R6 cfg locked", rd, pat(i, 2));
    end

    // R9 accept
    @(negedge clk);
    tgt_valid = 1'b1; #1;
    chk("R9 accept", DW'({tgt_retry, tgt_accept}), 1);
    @(negedge clk);
    tgt_valid = 1'b0;

    // R8 open path, parked on controller
    @(negedge clk);
    ob_valid = 1'b1; bus_req_ready = 1'b0; #1;
    chk("R8 busreq", DW'(bus_req_valid), 1);
    chk("R8 stall", DW'(ob_ready), 0);
    @(negedge clk);
    chk("R8 no done", DW'(ob_done), 0);
    bus_req_ready = 1'b1; #1;
    chk("R8 ready", DW'(ob_ready), 1);
    @(negedge clk);
    ob_valid = 1'b0; bus_req_ready = 1'b0;
    chk("R8 done ok", DW'({ob_done, ob_err}), 2);

    // R11 mask sweep from parked state
    for (int m = 1; m < 16; m++) begin
      @(negedge clk);
      ext_req = 4'(m);
      @(negedge clk);
      chk("R11 first grant", DW'(ext_gnt), DW'(4'(m) & (~4'(m) + 4'd1)));
      chk("R11 self off", DW'(self_gnt), 0);
      ext_req = '0;
      @(negedge clk);
      chk("R11 park", DW'({ext_gnt, self_gnt}), 1);
    end
    // R11 rotation with all requesting
    @(negedge clk);
    ext_req = 4'hF;
    @(negedge clk);
    for (int it = 0; it < 8; it++) begin
      chk("R11 rotate", DW'(ext_gnt), DW'(4'd1 << (it % 4)));
      ext_req = 4'hF & ~(4'd1 << (it % 4));
      @(negedge clk);
      ext_req = 4'hF;
    end
    // R11 hold while owner requests
    repeat (3) @(negedge clk);
    chk("R11 hold", DW'(ext_gnt), 1);
    ext_req = '0;
    @(negedge clk);

    // R2 disable after init; R3, R7 again
    cpu(1'b1, 4'd0, 0, rd);
    cpu(1'b0, 4'd2, '0, rd);
    chk("R3 read after disable", rd, 0);
    blocked_ob("R7 disabled after init");

    // ---------------- device mode ----------------
    do_reset(1'b0);
    @(negedge clk);
    strap_host = 1'b1;
    ext_req = 4'hF;
    tgt_valid = 1'b1; #1;
    chk("R9 device retry", DW'({tgt_retry, tgt_accept}), 2);
    tgt_valid = 1'b0;
    cpu(1'b1, 4'd0, 1, rd);
    cpu(1'b1, 4'd1, 1, rd);
    repeat (2) @(negedge clk);
    chk("R12 ext_gnt", DW'(ext_gnt), 0);
    chk("R13 strap ignored", DW'(self_gnt), 0);
    @(negedge clk);
    ob_valid = 1'b1; bus_req_ready = 1'b1; #1;
    chk("R12 no grant needed", DW'({bus_req_valid, ob_ready}), 3);
    @(negedge clk);
    ob_valid = 1'b0; bus_req_ready = 1'b0;
    chk("R12 done", DW'({ob_done, ob_err}), 2);
    ext_req = '0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule